// File: doc/BRIEF.md
# Fractional-Increment Timestamp Counter

This block keeps a free-running 64-bit time count held as a binary fixed-point number. Each time the local tick strobe is high, the block adds a programmable increment to the count. Because the count is binary fixed point, software turns it into nanoseconds with a right shift alone. Two worked examples of increment and shift:

| Tick period | Increment | Shift |
|---|---|---|
| 6.4 ns | 0x66666666 | 28 |
| 64 ns | 0x40000000 | 24 |

Software trims the frequency by rewriting the increment while the counter runs. A rewrite takes effect without disturbing the count already accumulated.

A 32-bit write port reaches three things: the increment register, a staged low count word, and the high count word. Writing the high word loads the staged low word together with it, so the count changes in a single cycle. A 32-bit read port returns the count as two words. Reading the low word captures the high word in a shadow, so a carry that happens between the two reads cannot tear the value.

A parameter selects one of two increment formats:
- Wide: a 31-bit increment.
- Narrow: a 24-bit increment plus an 8-bit period field. The increment is added once every P ticks.

Top module: `ftc_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the increment register is 0 and `rd_data` is 0.
- R2: In the wide format, each cycle with `tick` high adds the stored increment to the count. A cycle with `tick` low and no count load leaves the count unchanged.
- R3: A write to write address 0 sets the increment. A tick in the same cycle as the write still adds the old increment. The new value applies from the following tick on.
- R4: In the wide format, bit 31 of a written increment is discarded. Read address 2 returns the stored increment, and its bit 31 reads 0. In the narrow format, all 32 bits are stored and read back.
- R5: In the narrow format, bits 23:0 of the increment register are the step and bits 31:24 are a period P. One step is added on every P-th tick. P = 0 stops the count. Writing the increment restarts the tick phase, so the first step comes P ticks after the write.
- R6: A write to address 1 only stages a low word, and the count keeps running. A write to address 2 loads {written word, staged low word} into the count at that edge. That load wins over a tick in the same cycle.
- R7: A read at read address 0 returns count bits 31:0 and captures bits 63:32 in a shadow. A read at address 1 returns that shadow, however many ticks have passed since the low read.
- R8: `rd_data` is registered. It updates at the edge where `rd_en` is high and holds its value otherwise. Read address 3 returns 0.
- R9: The count wraps modulo 2^64 without saturating.
- R10: Writing 0 to the low word and then 0 to the high word clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Advance strobe for the time count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 increment, 1 staged low word, 2 high word and load, 3 none |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read source: 0 low word, 1 shadowed high word, 2 increment, 3 zero |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |

## Verification
The assertions assume that `tick`, the write strobes and the read strobes are held steady for a whole clock period and change only away from the rising edge. They also assume that a coherent read pairs a low read with a later high read, and that no other low read comes between the two. The bench drives every input at the falling edge and returns to idle just after the rising edge. Random operations come from a seeded `$urandom`, and the bench always issues the two reads of a count as a pair. Write address 3 and read address 3 are also drawn at random, so they are exercised inside the defined behaviour.

// File: rtl/ftc_pkg.sv
// Shared address codes for the fractional-increment timer.
// Assumes 2-bit write and read address buses.
package ftc_pkg;
    localparam logic [1:0] WR_INC  = 2'd0;
    localparam logic [1:0] WR_LO   = 2'd1;
    localparam logic [1:0] WR_HI   = 2'd2;
    localparam logic [1:0] RD_LO   = 2'd0;
    localparam logic [1:0] RD_HI   = 2'd1;
    localparam logic [1:0] RD_INC  = 2'd2;
    localparam logic [1:0] RD_ZERO = 2'd3;
endpackage

// File: rtl/ftc_inc_reg.sv
// Increment register and per-tick step decision.
// Wide variant: the low WIDE_INC_W bits are stored and every tick steps.
// Narrow variant: the low NAR_INC_W bits are the step and the upper bits a
// period P; one step is issued every P ticks, and P = 0 halts.
// Assumes tick and wr_inc are synchronous single-cycle strobes.
module ftc_inc_reg #(
    parameter int REG_W      = 32,
    parameter bit NARROW     = 1'b0,
    parameter int WIDE_INC_W = 31,
    parameter int NAR_INC_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_inc,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] inc_q,
    output logic [REG_W-1:0] step_inc,
    output logic             step
);
    localparam logic [REG_W-1:0] WIDE_MASK = (REG_W'(1) << WIDE_INC_W) - REG_W'(1);
    localparam logic [REG_W-1:0] NAR_MASK  = (REG_W'(1) << NAR_INC_W) - REG_W'(1);
    localparam int               PER_W     = REG_W - NAR_INC_W;

    logic [REG_W-1:0] inc_d;

    // Holds the increment; a write lands at the edge and is used from the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      inc_q <= '0;
        else if (wr_inc) inc_q <= inc_d;
    end

    generate
        if (NARROW) begin : g_narrow
            logic [PER_W-1:0] per_q;
            logic [PER_W-1:0] phase_q;
            logic             fire;

            assign inc_d    = wr_data;
            assign per_q    = inc_q[REG_W-1:NAR_INC_W];
            assign fire     = tick && (per_q != '0) && (phase_q == per_q - PER_W'(1));
            assign step     = fire;
            assign step_inc = inc_q & NAR_MASK;

            // Counts ticks inside the current period; an increment write restarts it.
            always_ff @(posedge clk) begin
                if (!rst_n)                    phase_q <= '0;
                else if (wr_inc)               phase_q <= '0;
                else if (tick && per_q != '0)  phase_q <= fire ? '0 : phase_q + PER_W'(1);
            end

            p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (per_q != '0) |-> (phase_q < per_q));
            p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (per_q == '0) |-> !step);
            p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_inc |=> (phase_q == '0));
        end else begin : g_wide
            assign inc_d    = wr_data & WIDE_MASK;
            assign step     = tick;
            assign step_inc = inc_q;

            p_top_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_q & ~WIDE_MASK) == '0);
        end
    endgenerate

    p_inc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inc |=> (inc_q == ($past(wr_data) & (NARROW ? {REG_W{1'b1}} : WIDE_MASK))));
    p_inc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_inc |=> $stable(inc_q));
endmodule

// File: rtl/ftc_accum.sv
// Time count accumulator with a staged low word and an atomic load.
// A high-word write loads {data, staged low} and takes priority over a step.
// Assumes wr_lo and wr_hi are never high in the same cycle (one write port).
module ftc_accum #(
    parameter int CNT_W = 64,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [REG_W-1:0] step_inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt
);
    localparam int EXT_W = CNT_W - REG_W;

    logic [REG_W-1:0] lo_stage;

    // Keeps the low word until a high-word write commits it.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_stage <= '0;
        else if (wr_lo) lo_stage <= wr_data;
    end

    // Loads the count or advances it by the step, wrapping modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_hi) cnt <= {wr_data, lo_stage};
        else if (step)  cnt <= cnt + {{EXT_W{1'b0}}, step_inc};
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_hi) |=> $stable(cnt));
    p_step_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_hi) |=> (cnt == $past(cnt) + {{EXT_W{1'b0}}, $past(step_inc)}));
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (cnt == {$past(wr_data), $past(lo_stage)}));
    p_stage_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_stage == $past(wr_data)));
endmodule

// File: rtl/ftc_rd_port.sv
// Registered read port with a coherent high-word shadow.
// A low read snapshots the high half; a high read returns that snapshot.
// Assumes software pairs a low read with a later high read.
module ftc_rd_port #(
    parameter int CNT_W = 64,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic [REG_W-1:0] inc_q,
    output logic [REG_W-1:0] rd_data
);
    import ftc_pkg::*;

    logic [REG_W-1:0] shadow;
    logic [REG_W-1:0] rd_mux;

    // Picks the word the current read returns.
    always_comb begin
        case (rd_sel)
            RD_LO:   rd_mux = cnt[REG_W-1:0];
            RD_HI:   rd_mux = shadow;
            RD_INC:  rd_mux = inc_q;
            default: rd_mux = '0;
        endcase
    end

    // Captures the upper half of the count on a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           shadow <= '0;
        else if (rd_en && rd_sel == RD_LO)    shadow <= cnt[CNT_W-1:REG_W];
    end

    // Registers the read result; holds it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    p_shadow_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == RD_LO) |=> (shadow == $past(cnt[CNT_W-1:REG_W])));
    p_high_from_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == RD_HI) |=> (rd_data == $past(shadow)));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == RD_ZERO) |=> (rd_data == '0));
endmodule

// File: rtl/ftc_timer.sv
// Fractional-increment timestamp counter (top).
// Decodes the write port, then connects the increment register, the
// accumulator and the read port. NARROW selects the increment format.
// Assumes CNT_W is exactly two register words.
module ftc_timer #(
    parameter int REG_W      = 32,
    parameter bit NARROW     = 1'b0,
    parameter int WIDE_INC_W = 31,
    parameter int NAR_INC_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data
);
    import ftc_pkg::*;

    localparam int CNT_W = 2 * REG_W;

    logic             wr_inc, wr_lo, wr_hi, step;
    logic [REG_W-1:0] inc_q, step_inc;
    logic [CNT_W-1:0] cnt;

    // Decodes the single write port into one strobe per target.
    always_comb begin
        wr_inc = wr_en && (wr_addr == WR_INC);
        wr_lo  = wr_en && (wr_addr == WR_LO);
        wr_hi  = wr_en && (wr_addr == WR_HI);
    end

    ftc_inc_reg #(
        .REG_W(REG_W), .NARROW(NARROW),
        .WIDE_INC_W(WIDE_INC_W), .NAR_INC_W(NAR_INC_W)
    ) u_inc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_inc(wr_inc),
        .wr_data(wr_data), .inc_q(inc_q), .step_inc(step_inc), .step(step)
    );

    ftc_accum #(.CNT_W(CNT_W), .REG_W(REG_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(step), .step_inc(step_inc),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .cnt(cnt)
    );

    ftc_rd_port #(.CNT_W(CNT_W), .REG_W(REG_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_addr),
        .cnt(cnt), .inc_q(inc_q), .rd_data(rd_data)
    );

    p_one_write_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_inc, wr_lo, wr_hi}));
    p_reset_state_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (cnt == '0 && inc_q == '0 && rd_data == '0));
endmodule

// File: tb/ftc_timer_test.sv
module ftc_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_w, rd_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Reference state: wide (w) and narrow (n) instances.
    logic [63:0] mw, mn;
    logic [31:0] iw, inn, sw, sn, ew, en, lo_stage;
    logic [7:0]  pcn;

    always #10 clk = ~clk;

    ftc_timer #(.NARROW(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_w)
    );

    ftc_timer #(.NARROW(1'b1)) uut_n (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_n)
    );

    function automatic logic [31:0] pick(input logic [1:0] ra, input logic [63:0] c,
                                         input logic [31:0] sh, input logic [31:0] inc);
        case (ra)
            2'd0: return c[31:0];
            2'd1: return sh;
            2'd2: return inc;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mw = '0; mn = '0; iw = '0; inn = '0; sw = '0; sn = '0;
        ew = '0; en = '0; lo_stage = '0; pcn = '0;
    endtask

    // One clock: drive at the falling edge, update models at the rising edge.
    task automatic cyc(input logic t, input logic we, input logic [1:0] wa,
                       input logic [31:0] wd, input logic re, input logic [1:0] ra);
        logic stn;
        logic [7:0] p;
        @(negedge clk);
        tick = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(posedge clk);
        if (re) begin
            ew = pick(ra, mw, sw, iw);
            en = pick(ra, mn, sn, inn);
            if (ra == 2'd0) begin sw = mw[63:32]; sn = mn[63:32]; end
        end
        p   = inn[31:24];
        stn = t && (p != 8'd0) && (pcn == p - 8'd1);
        if (we && wa == 2'd0)        pcn = 8'd0;
        else if (t && p != 8'd0)     pcn = stn ? 8'd0 : pcn + 8'd1;
        if (we && wa == 2'd2) begin
            mw = {wd, lo_stage}; mn = {wd, lo_stage};
        end else begin
            if (t)   mw = mw + {32'd0, iw};
            if (stn) mn = mn + {40'd0, inn[23:0]};
        end
        if (we && wa == 2'd1) lo_stage = wd;
        if (we && wa == 2'd0) begin iw = {1'b0, wd[30:0]}; inn = wd; end
        #1;
        tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 32'd0, 1'b0, 2'd0);
    endtask

    task automatic rdchk(input logic [1:0] ra, input logic t, input string tag);
        cyc(t, 1'b0, 2'd0, 32'd0, 1'b1, ra);
        @(negedge clk);
        chk({tag, " wide"}, rd_w, ew);
        chk({tag, " narrow"}, rd_n, en);
    endtask

    task automatic count_chk(input string tag);
        rdchk(2'd0, 1'b0, {tag, " lo"});
        rdchk(2'd1, 1'b0, {tag, " hi"});
    endtask

    task automatic wr(input logic [1:0] wa, input logic [31:0] wd, input logic t);
        cyc(t, 1'b1, wa, wd, 1'b0, 2'd0);
    endtask

    initial begin
        logic [31:0] held_w, held_n, r;
        void'($urandom(32'h5eed));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 rd_data after reset", rd_w, 32'd0);
        count_chk("R1 count");
        rdchk(2'd2, 1'b0, "R1 increment");

        // R2: plain ticking with a typical wide increment
        wr(2'd0, 32'h6666_6666, 1'b0);
        ticks(10);
        count_chk("R2 ten ticks");
        cyc(1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 2'd0);
        count_chk("R2 no tick holds");

        // R4: top bit dropped in wide format only
        wr(2'd0, 32'hE666_6666, 1'b0);
        rdchk(2'd2, 1'b0, "R4 increment readback");

        // R3: tick in the write cycle uses the old increment
        wr(2'd0, 32'h0100_0010, 1'b1);
        ticks(3);
        count_chk("R3 same-cycle update");

        // R5: narrow period 1, then 3, then halt
        ticks(5);
        count_chk("R5 period one");
        wr(2'd0, 32'h0300_0007, 1'b1);
        ticks(7);
        count_chk("R5 period three");
        wr(2'd0, 32'h0000_0055, 1'b0);
        ticks(6);
        count_chk("R5 period zero halts");

        // R6: staged low write does not disturb counting; high write commits
        wr(2'd0, 32'h0100_0100, 1'b0);
        wr(2'd1, 32'hDEAD_0000, 1'b1);
        ticks(4);
        count_chk("R6 staged only");
        wr(2'd2, 32'h0000_1234, 1'b1);
        count_chk("R6 load beats tick");

        // R7: carry between the two reads cannot tear the value
        wr(2'd0, 32'h7FFF_FFFF, 1'b0);
        wr(2'd1, 32'hFFFF_FF00, 1'b0);
        wr(2'd2, 32'h0000_0005, 1'b0);
        rdchk(2'd0, 1'b1, "R7 low read");
        ticks(8);
        rdchk(2'd1, 1'b1, "R7 shadow high read");
        chk("R7 shadow value", rd_w, 32'h0000_0005);

        // R9: wrap modulo 2^64
        wr(2'd1, 32'hFFFF_FFF0, 1'b0);
        wr(2'd2, 32'hFFFF_FFFF, 1'b0);
        ticks(2);
        count_chk("R9 wrap");

        // R10: zero load clears
        wr(2'd1, 32'd0, 1'b0);
        wr(2'd2, 32'd0, 1'b0);
        count_chk("R10 cleared");

        // R8: address 3 reads zero; rd_data holds with rd_en low
        ticks(3);
        rdchk(2'd0, 1'b0, "R8 low before idle");
        held_w = rd_w; held_n = rd_n;
        ticks(5);
        @(negedge clk);
        chk("R8 hold wide", rd_w, held_w);
        chk("R8 hold narrow", rd_n, held_n);
        rdchk(2'd3, 1'b0, "R8 zero address");

        // Random mix across R2 R3 R5 R6 R9
        for (int k = 0; k < 3000; k++) begin
            r = $urandom;
            case (r[3:0])
                4'd0: wr(2'd0, $urandom, r[4]);
                4'd1: wr(2'd0, {7'd0, r[5], 24'h0 | $urandom_range(32'hFFFFFF, 0)}, r[4]);
                4'd2: wr(2'd1, $urandom, r[4]);
                4'd3: wr(2'd2, $urandom, r[4]);
                4'd4: wr(2'd3, $urandom, r[4]);
                4'd5: count_chk("R2 random count");
                4'd6: rdchk(2'd2, r[4], "R5 random increment");
                4'd7: rdchk(2'd3, r[4], "R8 random zero");
                default: ticks(int'(r[7:4]) + 1);
            endcase
        end
        count_chk("R9 final count");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule